// File: doc/BRIEF.md
# UART Interrupt Status and Mask Unit

This block forms the interrupt side of a FIFO-based serial port. Each cycle it turns the receive and transmit FIFO fill counts and two programmable trigger levels into a live status word. It latches that word into a sticky interrupt register, together with single-cycle error and event pulses from the serial engine. It drives one level-sensitive interrupt line whenever a latched cause is also unmasked.

Software works through a small write port and a separate combinational read port. The mask can only be changed through two write-only addresses: one sets mask bits and the other removes them. Sticky causes are cleared by writing ones to them. If a cause is still present, or fires again, in the same cycle as its clear, the cause wins.

Top module: `uart_irq_unit`

## Requirements
- R1: The live status word is combinational from the counts and levels. Bit 0 is rx_count >= RX level and bit 1 is rx_count == 0. Bit 2 is rx_count == FIFO_DEPTH and bit 3 is tx_count == 0. Bit 4 is tx_count == FIFO_DEPTH and bit 13 is tx_count >= TX level. All other bits are 0.
- R2: Any of live bits 0 to 4 that is high sets the same bit of the sticky register at the next clock edge.
- R3: Live bit 13 (TX trigger) sets sticky bit 10 at the next clock edge.
- R4: The event pulses set these sticky bits at the next edge: ev_rx_ovr bit 5, ev_frame bit 6, ev_parity bit 7, ev_rx_tmo bit 8, ev_modem bit 9 and ev_tx_ovr bit 12.
- R5: A write to select 3 (sticky) clears each sticky bit written as 1 and leaves every other bit unchanged.
- R6: When a clear and a set of the same sticky bit fall in one cycle, the bit stays set.
- R7: A write to select 0 ORs wr_data into the mask. A write to select 1 removes the written bits from the mask. A write to select 2 leaves the mask unchanged. rd_sel 2 reads the mask.
- R8: irq is high exactly when some bit is set in both the mask and the sticky register.
- R9: During reset the mask and sticky registers read 0. Both trigger levels read 32 (rd_sel 4 for RX, 5 for TX; rd_sel 3 reads sticky).
- R10: Writes to select 4 and 5 load the RX and TX trigger levels, which read back unchanged. A level of 0 holds the matching trigger bit high whatever the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| rx_count | input | CNT_W | Receive FIFO fill level |
| tx_count | input | CNT_W | Transmit FIFO fill level |
| ev_rx_ovr | input | 1 | Receive overflow pulse |
| ev_tx_ovr | input | 1 | Transmit overflow pulse |
| ev_frame | input | 1 | Framing error pulse |
| ev_parity | input | 1 | Parity error pulse |
| ev_rx_tmo | input | 1 | Receive timeout pulse |
| ev_modem | input | 1 | Modem line change pulse |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Write select: 0 enable, 1 disable, 2 mask, 3 sticky, 4 RX level, 5 TX level |
| wr_data | input | 16 | Write data |
| rd_sel | input | 3 | Read select: 2 mask, 3 sticky, 4 RX level, 5 TX level, 6 live status |
| rd_data | output | 16 | Combinational read data |
| live_status | output | 16 | Live status word |
| irq | output | 1 | Level interrupt |

## Verification
A write-one-to-clear of the sticky register can land in the same cycle as a set of that bit. The set can come from an event pulse or from a live condition that still holds. The bench provokes both cases. It writes 0xFFFF to the sticky register while both FIFOs are full, which must leave bits 0, 2, 4 and 10 set and clear bits 1 and 3. It also drives a parity pulse on the same edge as a clear of bit 7, which must leave bit 7 set. The result is judged by reading the sticky register back on the following cycle.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int unsigned WORD_W = 16;
  localparam int unsigned NUM_EV = 6;

  // live status word bit positions
  localparam int unsigned LS_RX_TRIG  = 0;
  localparam int unsigned LS_RX_EMPTY = 1;
  localparam int unsigned LS_RX_FULL  = 2;
  localparam int unsigned LS_TX_EMPTY = 3;
  localparam int unsigned LS_TX_FULL  = 4;
  localparam int unsigned LS_TX_TRIG  = 13;

  // sticky register: TX trigger sits apart from its live position
  localparam int unsigned SK_TX_TRIG  = 10;

  // event index -> sticky bit: rx_ovr, frame, parity, rx_tmo, modem, tx_ovr
  localparam int unsigned EV_POS [NUM_EV] = '{5, 6, 7, 8, 9, 12};

  typedef enum logic [2:0] {
    SEL_EN   = 3'd0,
    SEL_DIS  = 3'd1,
    SEL_MASK = 3'd2,
    SEL_STK  = 3'd3,
    SEL_RXL  = 3'd4,
    SEL_TXL  = 3'd5,
    SEL_LIVE = 3'd6
  } reg_sel_e;
endpackage

// File: rtl/uart_irq_level_cfg.sv
module uart_irq_level_cfg
  import uart_irq_pkg::*;
#(
  parameter int unsigned CNT_W   = 7,
  parameter int unsigned RST_LVL = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [2:0]           wr_sel,
  input  logic [WORD_W-1:0]    wr_data,
  output logic [CNT_W-1:0]     rx_lvl,
  output logic [CNT_W-1:0]     tx_lvl
);
  logic [CNT_W-1:0] lvl [2];

  for (genvar c = 0; c < 2; c++) begin : g_lvl
    logic             we;
    logic [CNT_W-1:0] lvl_d;
    logic [CNT_W-1:0] lvl_q;

    assign we    = wr_en && (wr_sel == (3'(SEL_RXL) + 3'(c)));
    assign lvl_d = wr_data[CNT_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  lvl_q <= CNT_W'(RST_LVL);
      else if (we) lvl_q <= lvl_d;
    end

    assign lvl[c] = lvl_q;
  end

  assign rx_lvl = lvl[0];
  assign tx_lvl = lvl[1];
endmodule

// File: rtl/uart_irq_live.sv
module uart_irq_live
  import uart_irq_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 64,
  parameter int unsigned CNT_W      = 7
) (
  input  logic [CNT_W-1:0]  rx_count,
  input  logic [CNT_W-1:0]  tx_count,
  input  logic [CNT_W-1:0]  rx_lvl,
  input  logic [CNT_W-1:0]  tx_lvl,
  output logic [WORD_W-1:0] live
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(FIFO_DEPTH);

  always_comb begin
    live              = '0;
    live[LS_RX_TRIG]  = (rx_count >= rx_lvl);
    live[LS_RX_EMPTY] = (rx_count == '0);
    live[LS_RX_FULL]  = (rx_count == FULL_CNT);
    live[LS_TX_EMPTY] = (tx_count == '0);
    live[LS_TX_FULL]  = (tx_count == FULL_CNT);
    live[LS_TX_TRIG]  = (tx_count >= tx_lvl);
  end
endmodule

// File: rtl/uart_irq_mask.sv
module uart_irq_mask
  import uart_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_en,
  input  logic              clr_en,
  input  logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] mask_q
);
  logic [WORD_W-1:0] mask_d;
  logic              mask_ce;

  assign mask_ce = set_en | clr_en;

  always_comb begin
    mask_d = mask_q;
    if (set_en) mask_d = mask_q | wr_data;
    if (clr_en) mask_d = mask_q & ~wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_ce) mask_q <= mask_d;
  end
endmodule

// File: rtl/uart_irq_sticky.sv
module uart_irq_sticky
  import uart_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] live,
  input  logic [NUM_EV-1:0] ev,
  input  logic              clr_en,
  input  logic [WORD_W-1:0] clr_data,
  output logic [WORD_W-1:0] stat_q
);
  logic [WORD_W-1:0] set_w;
  logic [WORD_W-1:0] clr_w;
  logic [WORD_W-1:0] stat_d;
  logic              stat_ce;

  always_comb begin
    set_w             = '0;
    set_w[LS_TX_FULL:LS_RX_TRIG] = live[LS_TX_FULL:LS_RX_TRIG];
    set_w[SK_TX_TRIG] = live[LS_TX_TRIG];
    for (int i = 0; i < NUM_EV; i++) begin
      set_w[EV_POS[i]] = set_w[EV_POS[i]] | ev[i];
    end
  end

  assign clr_w   = clr_en ? clr_data : '0;
  // a set in the clearing cycle dominates
  assign stat_d  = (stat_q & ~clr_w) | set_w;
  assign stat_ce = clr_en | (|set_w);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       stat_q <= '0;
    else if (stat_ce) stat_q <= stat_d;
  end
endmodule

// File: rtl/uart_irq_unit.sv
module uart_irq_unit
  import uart_irq_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 64,
  parameter int unsigned CNT_W      = $clog2(FIFO_DEPTH + 1),
  parameter int unsigned RST_LVL    = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [CNT_W-1:0]     rx_count,
  input  logic [CNT_W-1:0]     tx_count,
  input  logic                 ev_rx_ovr,
  input  logic                 ev_tx_ovr,
  input  logic                 ev_frame,
  input  logic                 ev_parity,
  input  logic                 ev_rx_tmo,
  input  logic                 ev_modem,
  input  logic                 wr_en,
  input  logic [2:0]           wr_sel,
  input  logic [WORD_W-1:0]    wr_data,
  input  logic [2:0]           rd_sel,
  output logic [WORD_W-1:0]    rd_data,
  output logic [WORD_W-1:0]    live_status,
  output logic                 irq
);
  logic [CNT_W-1:0]  rx_lvl;
  logic [CNT_W-1:0]  tx_lvl;
  logic [WORD_W-1:0] mask_q;
  logic [WORD_W-1:0] stat_q;
  logic [NUM_EV-1:0] ev_vec;

  // order matches EV_POS in the package
  assign ev_vec = {ev_tx_ovr, ev_modem, ev_rx_tmo, ev_parity, ev_frame, ev_rx_ovr};

  uart_irq_level_cfg #(.CNT_W(CNT_W), .RST_LVL(RST_LVL)) i_lvl (
    .clk, .rst_n, .wr_en, .wr_sel, .wr_data, .rx_lvl, .tx_lvl
  );

  uart_irq_live #(.FIFO_DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) i_live (
    .rx_count, .tx_count, .rx_lvl, .tx_lvl, .live(live_status)
  );

  uart_irq_mask i_mask (
    .clk, .rst_n,
    .set_en (wr_en && (wr_sel == SEL_EN)),
    .clr_en (wr_en && (wr_sel == SEL_DIS)),
    .wr_data,
    .mask_q
  );

  uart_irq_sticky i_stk (
    .clk, .rst_n,
    .live     (live_status),
    .ev       (ev_vec),
    .clr_en   (wr_en && (wr_sel == SEL_STK)),
    .clr_data (wr_data),
    .stat_q
  );

  assign irq = |(mask_q & stat_q);

  always_comb begin
    case (rd_sel)
      SEL_MASK: rd_data = mask_q;
      SEL_STK:  rd_data = stat_q;
      SEL_RXL:  rd_data = WORD_W'(rx_lvl);
      SEL_TXL:  rd_data = WORD_W'(tx_lvl);
      SEL_LIVE: rd_data = live_status;
      default:  rd_data = '0;
    endcase
  end
endmodule

// File: rtl/uart_irq_chk.sv
module uart_irq_chk
  import uart_irq_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [2:0]        wr_sel,
  input logic [WORD_W-1:0] wr_data,
  input logic              ev_frame,
  input logic              ev_parity,
  input logic [WORD_W-1:0] live_status,
  input logic [WORD_W-1:0] mask_q,
  input logic [WORD_W-1:0] stat_q,
  input logic              irq
);
  assert_rx_empty_latch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    live_status[LS_RX_EMPTY] |=> stat_q[LS_RX_EMPTY]);

  assert_tx_trig_moved_R3: assert property (@(posedge clk) disable iff (!rst_n)
    live_status[LS_TX_TRIG] |=> stat_q[SK_TX_TRIG]);

  assert_frame_sticks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_frame |=> stat_q[6]);

  assert_w1c_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == SEL_STK && wr_data[7] && !ev_parity) |=> !stat_q[7]);

  assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == SEL_STK && wr_data[6] && ev_frame) |=> stat_q[6]);

  assert_mask_ro_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == SEL_MASK) |=> $stable(mask_q));

  assert_enable_or_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == SEL_EN) |=> ((mask_q & $past(wr_data)) == $past(wr_data)));

  assert_masked_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !irq);
endmodule

bind uart_irq_unit uart_irq_chk i_chk (
  .clk, .rst_n, .wr_en, .wr_sel, .wr_data, .ev_frame, .ev_parity,
  .live_status, .mask_q, .stat_q, .irq
);

// File: tb/test_uart_irq_unit.sv
module test_uart_irq_unit;
  localparam int CW = 7;

  logic clk = 1'b0;
  logic rst_n;
  logic [CW-1:0] rx_count, tx_count;
  logic ev_rx_ovr, ev_tx_ovr, ev_frame, ev_parity, ev_rx_tmo, ev_modem;
  logic wr_en;
  logic [2:0] wr_sel, rd_sel;
  logic [15:0] wr_data, rd_data, live_status;
  logic irq;

  always #5 clk = ~clk;

  uart_irq_unit i_uart_irq_unit (
    .clk, .rst_n, .rx_count, .tx_count, .ev_rx_ovr, .ev_tx_ovr, .ev_frame,
    .ev_parity, .ev_rx_tmo, .ev_modem, .wr_en, .wr_sel, .wr_data, .rd_sel,
    .rd_data, .live_status, .irq
  );

  typedef struct {
    int          kind;   // 0 rd_data, 1 irq, 2 live_status
    logic [15:0] exp;
    string       req;
  } exp_t;

  exp_t q[$];
  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  // monitor: compares queued expectations away from the active edge
  always @(negedge clk) begin
    while (q.size() > 0) begin
      exp_t e;
      logic [15:0] act;
      e = q.pop_front();
      case (e.kind)
        0:       act = rd_data;
        1:       act = {15'd0, irq};
        default: act = live_status;
      endcase
      n_tests++;
      if (act !== e.exp) begin
        n_fail++;
        $display("FAIL %s: actual 0x%04h expected 0x%04h", e.req, act, e.exp);
      end
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(input int kind, input logic [2:0] sel, input logic [15:0] exp, input string req);
    exp_t e;
    if (kind == 0) rd_sel = sel;
    e.kind = kind; e.exp = exp; e.req = req;
    q.push_back(e);
    tick();
  endtask

  task automatic wr(input logic [2:0] sel, input logic [15:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; rx_count = '0; tx_count = '0;
    ev_rx_ovr = 0; ev_tx_ovr = 0; ev_frame = 0; ev_parity = 0; ev_rx_tmo = 0; ev_modem = 0;
    wr_en = 0; wr_sel = '0; wr_data = '0; rd_sel = '0;
    tick(); tick();
    chk(0, 3'd2, 16'h0000, "R9 mask in reset");
    chk(0, 3'd3, 16'h0000, "R9 sticky in reset");
    chk(0, 3'd4, 16'd32,   "R9 rx level in reset");
    chk(0, 3'd5, 16'd32,   "R9 tx level in reset");
    rst_n = 1'b1;
    chk(2, 3'd0, 16'h000A, "R1 both empty");
    chk(0, 3'd3, 16'h000A, "R2 empties latched");
    chk(1, 3'd0, 16'h0000, "R8 irq masked");
    wr(3'd0, 16'h0002);
    chk(0, 3'd2, 16'h0002, "R7 enable sets mask");
    chk(1, 3'd0, 16'h0001, "R8 irq on");
    wr(3'd2, 16'hFFFF);
    chk(0, 3'd2, 16'h0002, "R7 mask write ignored");
    wr(3'd1, 16'h0002);
    chk(0, 3'd2, 16'h0000, "R7 disable clears mask");
    chk(1, 3'd0, 16'h0000, "R8 irq off");
    rx_count = 7'd32;
    chk(2, 3'd0, 16'h0009, "R1 rx at level");
    chk(0, 3'd3, 16'h000B, "R2 rx trigger latched");
    rx_count = 7'd64;
    chk(2, 3'd0, 16'h000D, "R1 rx full");
    chk(0, 3'd3, 16'h000F, "R2 rx full latched");
    tx_count = 7'd40;
    chk(2, 3'd0, 16'h2005, "R1 tx trigger");
    chk(0, 3'd3, 16'h040F, "R3 tx trigger to bit 10");
    tx_count = 7'd64;
    chk(2, 3'd0, 16'h2015, "R1 tx full");
    chk(0, 3'd3, 16'h041F, "R2 tx full latched");
    wr(3'd3, 16'hFFFF);
    chk(0, 3'd3, 16'h0415, "R6 live causes survive clear");
    ev_frame = 1; tick(); ev_frame = 0;
    chk(0, 3'd3, 16'h0455, "R4 frame bit 6");
    ev_rx_ovr = 1; tick(); ev_rx_ovr = 0;
    ev_parity = 1; tick(); ev_parity = 0;
    ev_rx_tmo = 1; tick(); ev_rx_tmo = 0;
    ev_modem  = 1; tick(); ev_modem  = 0;
    ev_tx_ovr = 1; tick(); ev_tx_ovr = 0;
    chk(0, 3'd3, 16'h17F5, "R4 all events");
    wr(3'd3, 16'h0040);
    chk(0, 3'd3, 16'h17B5, "R5 single bit cleared");
    wr_en = 1; wr_sel = 3'd3; wr_data = 16'h0080; ev_parity = 1;
    tick();
    wr_en = 0; ev_parity = 0;
    chk(0, 3'd3, 16'h17B5, "R6 parity set beats clear");
    wr(3'd0, 16'h1000);
    chk(1, 3'd0, 16'h0001, "R8 tx overflow unmasked");
    wr(3'd1, 16'h1000);
    chk(1, 3'd0, 16'h0000, "R8 disabled again");
    wr(3'd0, 16'h0008);
    chk(1, 3'd0, 16'h0000, "R8 mask on cleared cause");
    wr(3'd2, 16'hFFFF);
    chk(0, 3'd2, 16'h0008, "R7 mask still read only");
    wr(3'd1, 16'hFFFF);
    rx_count = '0; tx_count = '0;
    wr(3'd4, 16'h0000);
    chk(0, 3'd4, 16'h0000, "R10 rx level readback");
    chk(2, 3'd0, 16'h000B, "R10 rx level zero");
    wr(3'd5, 16'h0000);
    chk(2, 3'd0, 16'h200B, "R10 tx level zero");
    wr(3'd5, 16'd10);
    chk(0, 3'd5, 16'd10, "R10 tx level readback");
    tx_count = 7'd9;
    chk(2, 3'd0, 16'h0003, "R1 tx below level");
    tx_count = 7'd10;
    chk(2, 3'd0, 16'h2003, "R1 tx equal level");
    wr(3'd4, 16'd5);
    rx_count = 7'd4;
    chk(2, 3'd0, 16'h2000, "R1 rx below level");
    rx_count = 7'd5;
    chk(2, 3'd0, 16'h2001, "R1 rx equal level");
    tick();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule